// File: doc/BRIEF.md
# Software-Serviced Watchdog Timer

This block is a watchdog timer that firmware drives only through register writes. A single enable bit does two jobs. Writing 1 starts the timer when it is stopped, and restarts the count from zero when it is already running. Writing 0 stops it. A separate interval field picks the timeout. The timer counts an external millisecond tick. The timeout is the interval code plus a fixed base, multiplied by a fixed number of ticks per unit: (code + 2) × 32 ticks with the default parameters.

If firmware does not service the timer in time, the block does three things. It sets a sticky event flag, sends a one-cycle reset request to the rest of the chip, and stops itself, because that warm reset clears the enable bit. The event flag is not cleared by the warm reset it causes. After the reset, firmware can therefore tell a watchdog restart from a cold power-on. The flag is cleared only by writing 0 to the enable bit, or by the block's own hard reset. A new interval code written while the timer runs is held until the next start or restart.

Top module: `sw_watchdog`

## Requirements
- R1: After hard reset (`rst` high), `wd_event` and `wd_reset` are 0, the timer is stopped, and the interval code is 0.
- R2: A write of 1 to the enable bit (`en_wr` high with `en_wdata` 1) starts a stopped timer. If the timer is running, the same write clears its count, so the full timeout is counted again from that write.
- R3: The timeout is (code + BASE_UNITS) × UNIT_TICKS ticks of `tick_ms`, counted from the last start or restart. A tick sampled in the same cycle as the start is not counted. `wd_reset` is high in the cycle after the clock edge that samples the final tick.
- R4: On expiry, `wd_event` becomes 1 in the same cycle that `wd_reset` is high.
- R5: `wd_reset` is high for exactly one clock cycle per expiry.
- R6: Expiry stops the timer. No further `wd_reset` pulse occurs until the enable bit is written with 1 again.
- R7: `wd_event` stays 1 through the warm reset it causes and through writes of 1 to the enable bit. Only a write of 0 or a hard reset clears it.
- R8: A write of 0 to the enable bit stops the timer and clears `wd_event`, both visible in the next cycle. No pulse follows it.
- R9: A write to the interval field while the timer runs does not change the current timeout; the next start or restart uses it. Expiry does not clear the interval field.
- R10: When the interval field and the enable bit are written with 1 in the same cycle, the timer uses the newly written code.
- R11: An enable-bit write in the same cycle as the expiring tick takes precedence. A 1 restarts the count, a 0 stops the timer, and in neither case is `wd_reset` pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hard (power-on) reset |
| tick_ms | input | 1 | One-cycle millisecond tick strobe |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| ivl_wr | input | 1 | Write strobe for the interval field |
| ivl_wdata | input | IVL_W | Interval code written |
| wd_event | output | 1 | Sticky watchdog event flag |
| wd_reset | output | 1 | One-cycle warm reset request |

## Verification
The bench builds the block with IVL_W = 4 and BASE_UNITS = 2, and lowers UNIT_TICKS to 4. The longest timeout is then 68 ticks, so every interval code can reach expiry within a short run. Because 4 is a power of two, the shift-based limit calculation is the variant that gets built. With ticks driven by hand, a kick or a stop can be placed in exactly the cycle of the expiring tick. A long stretch of pseudo-random writes and ticks is compared cycle by cycle against a behavioural model. That stretch reaches races between interval updates and restarts, and flags that persist across several expiries.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // decoded enable-bit write
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_KICK = 2'd1,
    CMD_STOP = 2'd2
  } wr_cmd_e;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int unsigned max_limit(input int unsigned code_w,
                                            input int unsigned base,
                                            input int unsigned unit);
    return ((32'd1 << code_w) - 1 + base) * unit;
  endfunction

endpackage

// File: rtl/wdt_interval.sv
module wdt_interval #(
  parameter int IVL_W      = 4,
  parameter int BASE_UNITS = 2,
  parameter int UNIT_TICKS = 32,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ivl_wr,
  input  logic [IVL_W-1:0] ivl_wdata,
  input  logic             load,
  output logic [CNT_W-1:0] lim_o
);
  import wdt_pkg::*;

  localparam int SH = $clog2(UNIT_TICKS);
  localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(BASE_UNITS * UNIT_TICKS);

  logic [IVL_W-1:0] ivl_q;
  logic [IVL_W-1:0] sel;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_calc;

  // a write in the same cycle as a start is forwarded
  assign sel = ivl_wr ? ivl_wdata : ivl_q;

  generate
    if (is_pow2(UNIT_TICKS)) begin : g_shift
      assign lim_calc = CNT_W'((int'(sel) + BASE_UNITS) << SH);
    end else begin : g_mult
      assign lim_calc = CNT_W'((int'(sel) + BASE_UNITS) * UNIT_TICKS);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q <= '0;
      lim_q <= LIM_RST;
    end else begin
      if (ivl_wr) ivl_q <= ivl_wdata;
      if (load)   lim_q <= lim_calc;
    end
  end

  assign lim_o = lim_q;

  // R9
  lim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(lim_q));

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] lim,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = run && tick && (cnt_q == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (clr)         cnt_q <= '0;
    else if (run && tick) cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < lim));

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic hit,
  output logic run_o,
  output logic kick_o,
  output logic clr_o,
  output logic flag_o,
  output logic pulse_o
);
  import wdt_pkg::*;

  wr_cmd_e cmd;
  logic    run_q;
  logic    flag_q;
  logic    pulse_q;

  always_comb begin
    if (!en_wr)        cmd = CMD_NONE;
    else if (en_wdata) cmd = CMD_KICK;
    else               cmd = CMD_STOP;
  end

  assign kick_o = (cmd == CMD_KICK);
  assign clr_o  = en_wr || hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      case (cmd)
        CMD_KICK: run_q <= 1'b1;
        CMD_STOP: begin
          run_q  <= 1'b0;
          flag_q <= 1'b0;
        end
        default: begin
          if (hit) begin
            run_q   <= 1'b0;   // warm reset clears the enable bit
            flag_q  <= 1'b1;
            pulse_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign run_o   = run_q;
  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;

  // R5
  pulse_one_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);

  // R4
  pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> flag_q);

  // R6
  pulse_stop_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> !run_q);

  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(en_wr && !en_wdata)) |=> flag_q);

  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (en_wr && !en_wdata) |=> (!flag_q && !run_q && !pulse_q));

  // R11
  kick_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (en_wr && en_wdata) |=> (run_q && !pulse_q));

endmodule

// File: rtl/sw_watchdog.sv
module sw_watchdog #(
  parameter int IVL_W      = 4,
  parameter int BASE_UNITS = 2,
  parameter int UNIT_TICKS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_ms,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             ivl_wr,
  input  logic [IVL_W-1:0] ivl_wdata,
  output logic             wd_event,
  output logic             wd_reset
);
  import wdt_pkg::*;

  localparam int MAX_LIM = int'(max_limit(IVL_W, BASE_UNITS, UNIT_TICKS));
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic             run;
  logic             kick;
  logic             clr;
  logic             hit;
  logic [CNT_W-1:0] lim;

  wdt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .hit      (hit),
    .run_o    (run),
    .kick_o   (kick),
    .clr_o    (clr),
    .flag_o   (wd_event),
    .pulse_o  (wd_reset)
  );

  wdt_interval #(
    .IVL_W      (IVL_W),
    .BASE_UNITS (BASE_UNITS),
    .UNIT_TICKS (UNIT_TICKS),
    .CNT_W      (CNT_W)
  ) u_ivl (
    .clk       (clk),
    .rst       (rst),
    .ivl_wr    (ivl_wr),
    .ivl_wdata (ivl_wdata),
    .load      (kick),
    .lim_o     (lim)
  );

  wdt_count #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .run   (run),
    .tick  (tick_ms),
    .lim   (lim),
    .hit_o (hit)
  );

endmodule

// File: tb/sw_watchdog_tb_top.sv
module sw_watchdog_tb_top;
  localparam int IVL_W = 4;
  localparam int BASE  = 2;
  localparam int UNIT  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick_ms = 1'b0;
  logic             en_wr = 1'b0;
  logic             en_wdata = 1'b0;
  logic             ivl_wr = 1'b0;
  logic [IVL_W-1:0] ivl_wdata = '0;
  logic             wd_event;
  logic             wd_reset;

  int checks = 0;
  int errors = 0;
  int cyc_n  = 0;
  int tks    = 0;
  bit done   = 0;

  // reference model state
  int m_run = 0, m_cnt = 0, m_lim = BASE * UNIT, m_code = 0, m_flag = 0, m_pulse = 0;

  always #2 clk = ~clk;   // 250 MHz

  sw_watchdog #(.IVL_W(IVL_W), .BASE_UNITS(BASE), .UNIT_TICKS(UNIT)) dut_i (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .en_wr(en_wr), .en_wdata(en_wdata),
    .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata), .wd_event(wd_event), .wd_reset(wd_reset)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ticks since the last enable write of 1
  always @(posedge clk) begin
    if (rst || (en_wr && en_wdata)) tks <= 0;
    else if (tick_ms)               tks <= tks + 1;
  end

  // behavioural reference model
  always @(posedge clk) begin
    int nc;
    bit hit;
    if (rst) begin
      m_run = 0; m_cnt = 0; m_lim = BASE * UNIT; m_code = 0; m_flag = 0; m_pulse = 0;
    end else begin
      nc = ivl_wr ? int'(ivl_wdata) : m_code;
      hit = (m_run != 0) && tick_ms && (m_cnt + 1 == m_lim);
      m_pulse = 0;
      if (en_wr && en_wdata) begin
        m_run = 1; m_cnt = 0; m_lim = (nc + BASE) * UNIT;
      end else if (en_wr) begin
        m_run = 0; m_cnt = 0; m_flag = 0;
      end else if (hit) begin
        m_run = 0; m_cnt = 0; m_flag = 1; m_pulse = 1;
      end else if (m_run != 0 && tick_ms) begin
        m_cnt++;
      end
      m_code = nc;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R4/R7/R8 model wd_event", int'(wd_event), m_flag);
      chk("R3/R5 model wd_reset", int'(wd_reset), m_pulse);
    end
  end

  // one cycle of stimulus; mt=1 selects a manual tick value tk
  task automatic cyc(input bit ew, input bit ed, input bit iw, input logic [3:0] id,
                     input bit mt, input bit tk);
    @(negedge clk);
    cyc_n++;
    tick_ms   <= mt ? tk : (cyc_n % 2 == 0);
    en_wr     <= ew;
    en_wdata  <= ed;
    ivl_wr    <= iw;
    ivl_wdata <= id;
  endtask

  task automatic wait_pulse(input int maxc, output bit got, output int t);
    got = 0; t = -1;
    for (int i = 0; i < maxc && !got; i++) begin
      cyc(0, 0, 0, 4'd0, 0, 0);
      if (wd_reset) begin got = 1; t = tks; end
    end
  endtask

  task automatic count_pulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 4'd0, 0, 0);
      if (wd_reset) p++;
    end
  endtask

  initial begin
    bit got;
    int t, p;
    repeat (4) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk("R1 reset wd_event", int'(wd_event), 0);
    chk("R1 reset wd_reset", int'(wd_reset), 0);

    // R1/R3: default code 0 -> 8 ticks
    cyc(1, 1, 0, 4'd0, 0, 0);
    wait_pulse(400, got, t);
    chk("R3 expiry seen", int'(got), 1);
    chk("R1/R3 ticks at code 0", t, BASE * UNIT);
    chk("R4 flag with pulse", int'(wd_event), 1);
    cyc(0, 0, 0, 4'd0, 0, 0);
    chk("R5 pulse one cycle", int'(wd_reset), 0);
    count_pulses(100, p);
    chk("R6 no pulse after expiry", p, 0);
    chk("R7 flag survives warm reset", int'(wd_event), 1);

    // R2 kicks keep it alive, R7 write of 1 keeps flag
    cyc(1, 1, 0, 4'd0, 0, 0);
    cyc(0, 0, 0, 4'd0, 0, 0);
    chk("R7 flag after write 1", int'(wd_event), 1);
    p = 0;
    for (int k = 0; k < 20; k++) begin
      int q;
      count_pulses(9, q);
      p += q;
      cyc(1, 1, 0, 4'd0, 0, 0);
    end
    chk("R2 kicked timer never expires", p, 0);

    // R8 stop clears flag
    cyc(1, 0, 0, 4'd0, 0, 0);
    cyc(0, 0, 0, 4'd0, 0, 0);
    chk("R8 flag cleared by write 0", int'(wd_event), 0);
    count_pulses(60, p);
    chk("R8 no pulse after stop", p, 0);

    // R9 code change while running waits for restart
    cyc(0, 0, 1, 4'd5, 0, 0);
    cyc(1, 1, 0, 4'd0, 0, 0);
    repeat (10) cyc(0, 0, 0, 4'd0, 0, 0);
    cyc(0, 0, 1, 4'd1, 0, 0);
    wait_pulse(400, got, t);
    chk("R9 running period keeps old code", t, (5 + BASE) * UNIT);
    cyc(1, 1, 0, 4'd0, 0, 0);
    wait_pulse(400, got, t);
    chk("R9 restart uses new code", t, (1 + BASE) * UNIT);

    // R10 simultaneous code and enable write
    cyc(1, 1, 1, 4'd3, 0, 0);
    wait_pulse(400, got, t);
    chk("R10 same-cycle code used", t, (3 + BASE) * UNIT);

    // R11 kick on the expiring tick
    cyc(1, 1, 1, 4'd0, 1, 0);
    for (int i = 0; i < BASE * UNIT - 1; i++) cyc(0, 0, 0, 4'd0, 1, 1);
    cyc(1, 1, 0, 4'd0, 1, 1);
    cyc(0, 0, 0, 4'd0, 1, 0);
    chk("R11 kick beats expiring tick", int'(wd_reset), 0);
    p = 0;
    for (int i = 0; i < BASE * UNIT; i++) begin
      cyc(0, 0, 0, 4'd0, 1, 1);
      if (wd_reset) p++;
    end
    chk("R2 restart counts from zero", p, 0);
    cyc(0, 0, 0, 4'd0, 1, 0);
    chk("R2 expiry after full restart", int'(wd_reset), 1);

    // R11 stop on the expiring tick
    cyc(1, 1, 0, 4'd0, 1, 0);
    for (int i = 0; i < BASE * UNIT - 1; i++) cyc(0, 0, 0, 4'd0, 1, 1);
    cyc(1, 0, 0, 4'd0, 1, 1);
    cyc(0, 0, 0, 4'd0, 1, 0);
    chk("R11 stop beats expiring tick", int'(wd_reset), 0);
    chk("R11 stop clears flag", int'(wd_event), 0);
    count_pulses(40, p);
    chk("R11 stays stopped", p, 0);

    // R7 hard reset clears flag and code
    cyc(1, 1, 1, 4'd2, 0, 0);
    wait_pulse(400, got, t);
    @(negedge clk);
    rst <= 1'b1;
    @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk("R1/R7 hard reset clears flag", int'(wd_event), 0);
    cyc(1, 1, 0, 4'd0, 0, 0);
    wait_pulse(400, got, t);
    chk("R1 code back to 0", t, BASE * UNIT);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit ew, iw;
      ew = ($urandom_range(0, 19) == 0);
      iw = ($urandom_range(0, 29) == 0);
      cyc(ew, ($urandom_range(0, 3) != 0), iw, 4'($urandom_range(0, 15)), 0, 0);
    end
    cyc(0, 0, 0, 4'd0, 0, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule